// File: doc/BRIEF.md
# Integer Execute Unit for a 16-bit Load/Store Instruction Set

This block is the purely combinational execute stage of a small 16-bit processor. Each cycle it receives the 5-bit operation code, the two source register values, the present value of the destination register and the upper byte of the instruction word, which holds the immediates. It returns the 16-bit value to be written back to the destination register.

It covers four groups of work: wrapping add and subtract, three shifts, three bitwise operations, and five compares that write 0 or 1. It also builds immediates: an add with a sign-extended short immediate, and a pair of operations that assemble a constant one byte at a time. A valid output tells the surrounding pipeline whether the opcode belongs to this unit. Loads, stores, branches, special-register access and the register file itself are handled elsewhere.

The unit has no state. A decoder turns the opcode into a result select. Separate adder, shifter and logic/compare units run in parallel, and a final multiplexer picks one of their outputs.

Top module: `fisa_exec_unit`

## Requirements
- R1: Opcode 0x00 returns rs1 + rs2 and opcode 0x01 returns rs1 - rs2, both modulo 2^16.
- R2: Opcode 0x02 returns rs1 shifted left by rs2[3:0] with zeros shifted in. The upper 12 bits of rs2 are ignored.
- R3: Opcode 0x03 shifts rs1 right by rs2[3:0] and fills with zeros. Opcode 0x04 shifts right by rs2[3:0] and fills with copies of rs1[15].
- R4: Opcode 0x05 returns rs1 plus the 5-bit field at instruction bits 15:11 (imm_hi_i[7:3]), sign-extended to 16 bits, modulo 2^16.
- R5: Opcode 0x06 returns instruction bits 15:8 (imm_hi_i) in result bits 15:8, with result bits 7:0 cleared.
- R6: Opcode 0x07 returns rd_cur_i[15:8] in result bits 15:8 and imm_hi_i in result bits 7:0.
- R7: Opcodes 0x10, 0x11 and 0x12 return rs1 AND rs2, rs1 OR rs2 and rs1 XOR rs2.
- R8: Opcode 0x13 tests rs1 == rs2, opcode 0x14 tests signed rs1 > rs2, and opcode 0x15 tests signed rs1 >= rs2. Each returns 16'd1 when the test holds and 16'd0 when it does not.
- R9: Opcode 0x16 tests unsigned rs1 > rs2 and opcode 0x17 tests unsigned rs1 >= rs2. Each returns 16'd1 or 16'd0.
- R10: valid_o is 1 exactly for opcodes 0x00-0x07 and 0x10-0x17. For every other opcode valid_o is 0 and result_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| rs1_i | input | 16 | First source register value |
| rs2_i | input | 16 | Second source register value |
| rd_cur_i | input | 16 | Current value of the destination register |
| imm_hi_i | input | 8 | Instruction bits 15:8 (8-bit immediate; bits 7:3 form the 5-bit immediate) |
| result_o | output | 16 | Value to write back to the destination register |
| valid_o | output | 1 | Opcode is handled by this unit |

## Verification
All 32 opcodes are applied to every pair taken from a set of edge operands: zero, one, the largest and smallest signed values, all ones, and alternating-bit words. This set separates signed compares from unsigned ones, and shows whether add and subtract wrap at the carry boundary. Shift amounts are swept over 0 to 31 on words with the sign bit both set and clear. This separates the zero-filling right shift from the sign-filling one and shows that the upper bits of rs2 are ignored. The full 8-bit immediate range is swept through the three immediate-construction opcodes with a nonzero destination value. A pseudo-random run then mixes opcodes and operands.

// File: rtl/fisa_exec_pkg.sv
package fisa_exec_pkg;

    typedef enum logic [4:0] {
        OPC_ADD  = 5'h00,
        OPC_SUB  = 5'h01,
        OPC_SHL  = 5'h02,
        OPC_SHRL = 5'h03,
        OPC_SHRA = 5'h04,
        OPC_ADDI = 5'h05,
        OPC_HIGH = 5'h06,
        OPC_LOW  = 5'h07,
        OPC_AND  = 5'h10,
        OPC_OR   = 5'h11,
        OPC_XOR  = 5'h12,
        OPC_CEQ  = 5'h13,
        OPC_CGTS = 5'h14,
        OPC_CGES = 5'h15,
        OPC_CGTU = 5'h16,
        OPC_CGEU = 5'h17
    } opcode_e;

    typedef enum logic [4:0] {
        PICK_NONE,
        PICK_SUM,
        PICK_DIFF,
        PICK_SHL,
        PICK_SHRL,
        PICK_SHRA,
        PICK_ADDI,
        PICK_HIGH,
        PICK_LOW,
        PICK_AND,
        PICK_OR,
        PICK_XOR,
        PICK_EQ,
        PICK_GTS,
        PICK_GES,
        PICK_GTU,
        PICK_GEU
    } pick_e;

endpackage

// File: rtl/fisa_exec_decode.sv
module fisa_exec_decode
    import fisa_exec_pkg::*;
(
    input  logic [4:0] op_i,
    output pick_e      pick_o,
    output logic       valid_o
);

    always_comb begin
        unique case (op_i)
            OPC_ADD:  pick_o = PICK_SUM;
            OPC_SUB:  pick_o = PICK_DIFF;
            OPC_SHL:  pick_o = PICK_SHL;
            OPC_SHRL: pick_o = PICK_SHRL;
            OPC_SHRA: pick_o = PICK_SHRA;
            OPC_ADDI: pick_o = PICK_ADDI;
            OPC_HIGH: pick_o = PICK_HIGH;
            OPC_LOW:  pick_o = PICK_LOW;
            OPC_AND:  pick_o = PICK_AND;
            OPC_OR:   pick_o = PICK_OR;
            OPC_XOR:  pick_o = PICK_XOR;
            OPC_CEQ:  pick_o = PICK_EQ;
            OPC_CGTS: pick_o = PICK_GTS;
            OPC_CGES: pick_o = PICK_GES;
            OPC_CGTU: pick_o = PICK_GTU;
            OPC_CGEU: pick_o = PICK_GEU;
            default:  pick_o = PICK_NONE;
        endcase
    end

    assign valid_o = (pick_o != PICK_NONE);

endmodule

// File: rtl/fisa_exec_adder.sv
module fisa_exec_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] imm_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] diff_o,
    output logic [W-1:0] addi_o
);

    assign sum_o  = a_i + b_i;
    assign diff_o = a_i - b_i;
    assign addi_o = a_i + imm_i;

endmodule

// File: rtl/fisa_exec_shifter.sv
module fisa_exec_shifter #(
    parameter int W = 16
) (
    input  logic [W-1:0]         a_i,
    input  logic [$clog2(W)-1:0] amt_i,
    output logic [W-1:0]         shl_o,
    output logic [W-1:0]         shrl_o,
    output logic [W-1:0]         shra_o
);

    localparam int STAGES = $clog2(W);

    logic [W-1:0] lft [STAGES+1];
    logic [W-1:0] rzf [STAGES+1];
    logic [W-1:0] rsf [STAGES+1];

    assign lft[0] = a_i;
    assign rzf[0] = a_i;
    assign rsf[0] = a_i;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int D = 1 << k;
        assign lft[k+1] = amt_i[k] ? {lft[k][W-1-D:0], {D{1'b0}}} : lft[k];
        assign rzf[k+1] = amt_i[k] ? {{D{1'b0}}, rzf[k][W-1:D]} : rzf[k];
        assign rsf[k+1] = amt_i[k] ? {{D{rsf[k][W-1]}}, rsf[k][W-1:D]} : rsf[k];
    end

    assign shl_o  = lft[STAGES];
    assign shrl_o = rzf[STAGES];
    assign shra_o = rsf[STAGES];

    // With a clear sign bit the two right-shift chains must agree
    always_comb begin
        if (!a_i[W-1]) begin
            assert_shr_agree_R3: assert (shra_o == shrl_o)
                else $error("R3: sign-fill and zero-fill shifts differ on positive operand");
        end
        if (a_i[W-1] && amt_i != '0) begin
            assert_shr_fill_R3: assert (shra_o[W-1] && !shrl_o[W-1])
                else $error("R3: fill bit wrong on negative operand");
        end
    end

endmodule

// File: rtl/fisa_exec_logic.sv
module fisa_exec_logic #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] xor_o,
    output logic         eq_o,
    output logic         gts_o,
    output logic         ges_o,
    output logic         gtu_o,
    output logic         geu_o
);

    assign and_o = a_i & b_i;
    assign or_o  = a_i | b_i;
    assign xor_o = a_i ^ b_i;

    assign eq_o  = (a_i == b_i);
    assign gts_o = $signed(a_i) >  $signed(b_i);
    assign ges_o = $signed(a_i) >= $signed(b_i);
    assign gtu_o = a_i >  b_i;
    assign geu_o = a_i >= b_i;

    always_comb begin
        assert_gt_eq_excl_R8: assert (!(gts_o && eq_o) && !(gtu_o && eq_o))
            else $error("R8: greater-than and equal both set");
        assert_ges_split_R8: assert (ges_o == (gts_o || eq_o))
            else $error("R8: signed >= disagrees with > or ==");
        assert_geu_split_R9: assert (geu_o == (gtu_o || eq_o))
            else $error("R9: unsigned >= disagrees with > or ==");
        assert_xor_eq_R7: assert (eq_o == (xor_o == '0))
            else $error("R7: xor result inconsistent with equality");
    end

endmodule

// File: rtl/fisa_exec_unit.sv
module fisa_exec_unit
    import fisa_exec_pkg::*;
#(
    parameter int W     = 16,
    parameter int SIMMW = 5
) (
    input  logic [4:0]     op_i,
    input  logic [W-1:0]   rs1_i,
    input  logic [W-1:0]   rs2_i,
    input  logic [W-1:0]   rd_cur_i,
    input  logic [W/2-1:0] imm_hi_i,
    output logic [W-1:0]   result_o,
    output logic           valid_o
);

    localparam int HALF = W / 2;
    localparam int SHW  = $clog2(W);

    pick_e        pick;
    logic [W-1:0] simm_ext;
    logic [W-1:0] sum, diff, addi;
    logic [W-1:0] shl, shrl, shra;
    logic [W-1:0] v_and, v_or, v_xor;
    logic         c_eq, c_gts, c_ges, c_gtu, c_geu;
    logic [W-1:0] high_word, low_word;

    assign simm_ext  = {{(W-SIMMW){imm_hi_i[HALF-1]}}, imm_hi_i[HALF-1 -: SIMMW]};
    assign high_word = {imm_hi_i, {HALF{1'b0}}};
    assign low_word  = {rd_cur_i[W-1:HALF], imm_hi_i};

    fisa_exec_decode u_dec (
        .op_i    (op_i),
        .pick_o  (pick),
        .valid_o (valid_o)
    );

    fisa_exec_adder #(.W(W)) u_add (
        .a_i    (rs1_i),
        .b_i    (rs2_i),
        .imm_i  (simm_ext),
        .sum_o  (sum),
        .diff_o (diff),
        .addi_o (addi)
    );

    fisa_exec_shifter #(.W(W)) u_shf (
        .a_i    (rs1_i),
        .amt_i  (rs2_i[SHW-1:0]),
        .shl_o  (shl),
        .shrl_o (shrl),
        .shra_o (shra)
    );

    fisa_exec_logic #(.W(W)) u_log (
        .a_i   (rs1_i),
        .b_i   (rs2_i),
        .and_o (v_and),
        .or_o  (v_or),
        .xor_o (v_xor),
        .eq_o  (c_eq),
        .gts_o (c_gts),
        .ges_o (c_ges),
        .gtu_o (c_gtu),
        .geu_o (c_geu)
    );

    always_comb begin
        unique case (pick)
            PICK_SUM:  result_o = sum;
            PICK_DIFF: result_o = diff;
            PICK_SHL:  result_o = shl;
            PICK_SHRL: result_o = shrl;
            PICK_SHRA: result_o = shra;
            PICK_ADDI: result_o = addi;
            PICK_HIGH: result_o = high_word;
            PICK_LOW:  result_o = low_word;
            PICK_AND:  result_o = v_and;
            PICK_OR:   result_o = v_or;
            PICK_XOR:  result_o = v_xor;
            PICK_EQ:   result_o = W'(c_eq);
            PICK_GTS:  result_o = W'(c_gts);
            PICK_GES:  result_o = W'(c_ges);
            PICK_GTU:  result_o = W'(c_gtu);
            PICK_GEU:  result_o = W'(c_geu);
            default:   result_o = '0;
        endcase
    end

    always_comb begin
        if (!valid_o) begin
            assert_idle_zero_R10: assert (result_o == '0)
                else $error("R10: nonzero result on unhandled opcode");
        end
        assert_eq_by_diff_R8: assert (c_eq == (diff == '0))
            else $error("R8: equality disagrees with subtractor");
        if (op_i == OPC_LOW) begin
            assert_low_keeps_R6: assert (result_o[W-1:HALF] == rd_cur_i[W-1:HALF])
                else $error("R6: upper byte not preserved");
        end
        if (op_i == OPC_HIGH) begin
            assert_high_clear_R5: assert (result_o[HALF-1:0] == '0)
                else $error("R5: low byte not cleared");
        end
        if (op_i[4:3] == 2'b11 || op_i[4:3] == 2'b01) begin
            assert_outside_invalid_R10: assert (!valid_o)
                else $error("R10: valid on opcode outside handled groups");
        end
    end

endmodule

// File: tb/fisa_exec_unit_tb.sv
`timescale 1ns/1ps
module fisa_exec_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op;
    logic [15:0] rs1, rs2, rdc;
    logic [7:0]  imm;
    logic [15:0] res;
    logic        vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fisa_exec_unit dut_i (
        .op_i     (op),
        .rs1_i    (rs1),
        .rs2_i    (rs2),
        .rd_cur_i (rdc),
        .imm_hi_i (imm),
        .result_o (res),
        .valid_o  (vld)
    );

    function automatic string tag_of(input logic [4:0] o);
        case (o)
            5'h00, 5'h01: return "R1";
            5'h02:        return "R2";
            5'h03, 5'h04: return "R3";
            5'h05:        return "R4";
            5'h06:        return "R5";
            5'h07:        return "R6";
            5'h10, 5'h11, 5'h12: return "R7";
            5'h13, 5'h14, 5'h15: return "R8";
            5'h16, 5'h17: return "R9";
            default:      return "R10";
        endcase
    endfunction

    function automatic logic [15:0] model(input logic [4:0] o, input logic [15:0] a,
                                          input logic [15:0] b, input logic [15:0] d,
                                          input logic [7:0] i8);
        int sa, sb, n, acc;
        sa = $signed(a);
        sb = $signed(b);
        n  = b % 16;
        case (o)
            5'h00: acc = int'(a) + int'(b);
            5'h01: acc = int'(a) - int'(b);
            5'h02: acc = int'(a) * (1 << n);
            5'h03: acc = int'(a) / (1 << n);
            5'h04: acc = (sa < 0) ? -(((-sa) + (1 << n) - 1) / (1 << n)) : sa / (1 << n);
            5'h05: acc = int'(a) + ((int'(i8) / 8 >= 16) ? int'(i8) / 8 - 32 : int'(i8) / 8);
            5'h06: acc = int'(i8) * 256;
            5'h07: acc = (int'(d) / 256) * 256 + int'(i8);
            5'h10: acc = int'(a & b);
            5'h11: acc = int'(a | b);
            5'h12: acc = int'(a ^ b);
            5'h13: acc = (a == b) ? 1 : 0;
            5'h14: acc = (sa > sb) ? 1 : 0;
            5'h15: acc = (sa >= sb) ? 1 : 0;
            5'h16: acc = (int'(a) > int'(b)) ? 1 : 0;
            5'h17: acc = (int'(a) >= int'(b)) ? 1 : 0;
            default: acc = 0;
        endcase
        return acc[15:0];
    endfunction

    task automatic apply_and_check(input logic [4:0] o, input logic [15:0] a,
                                   input logic [15:0] b, input logic [15:0] d,
                                   input logic [7:0] i8);
        logic [15:0] exp_r;
        logic        exp_v;
        op = o; rs1 = a; rs2 = b; rdc = d; imm = i8;
        @(negedge clk);
        exp_r = model(o, a, b, d, i8);
        exp_v = (o < 5'h08) || (o >= 5'h10 && o < 5'h18);
        checks++;
        if (res !== exp_r) begin
            errors++;
            $display("FAIL %s result op=%02h a=%04h b=%04h rd=%04h imm=%02h: actual %04h expected %04h",
                     tag_of(o), o, a, b, d, i8, res, exp_r);
        end
        checks++;
        if (vld !== exp_v) begin
            errors++;
            $display("FAIL R10 valid op=%02h: actual %0b expected %0b", o, vld, exp_v);
        end
    endtask

    logic [15:0] corners [8];

    initial begin
        corners[0] = 16'h0000; corners[1] = 16'h0001;
        corners[2] = 16'h7FFF; corners[3] = 16'h8000;
        corners[4] = 16'hFFFF; corners[5] = 16'h00FF;
        corners[6] = 16'h5555; corners[7] = 16'hAAAA;
        op = '0; rs1 = '0; rs2 = '0; rdc = '0; imm = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Initial state: all-zero inputs (ADD of zeros), R1 and R10
        apply_and_check(5'h00, 16'h0000, 16'h0000, 16'h0000, 8'h00);

        // R1..R10 sweep: every opcode over every corner pair
        for (int o = 0; o < 32; o++)
            for (int x = 0; x < 8; x++)
                for (int y = 0; y < 8; y++)
                    apply_and_check(5'(o), corners[x], corners[y], corners[y], 8'(corners[x] ^ 16'(y * 37)));

        // R2 and R3: shift amounts 0..31, sign bit set and clear, upper rs2 bits nonzero
        for (int s = 0; s < 32; s++) begin
            apply_and_check(5'h02, 16'hB38D, 16'(s) | 16'hA5A0, 16'h0, 8'h0);
            apply_and_check(5'h03, 16'hB38D, 16'(s), 16'h0, 8'h0);
            apply_and_check(5'h04, 16'hB38D, 16'(s) | 16'h7F00, 16'h0, 8'h0);
            apply_and_check(5'h04, 16'h438D, 16'(s), 16'h0, 8'h0);
            apply_and_check(5'h03, 16'h8000, 16'(s), 16'h0, 8'h0);
        end

        // R4, R5, R6: full immediate range with nonzero destination value
        for (int i = 0; i < 256; i++) begin
            apply_and_check(5'h05, 16'h7FFE, 16'h0, 16'h0, 8'(i));
            apply_and_check(5'h05, 16'h0003, 16'h0, 16'h0, 8'(i));
            apply_and_check(5'h06, 16'h1234, 16'h0, 16'hC3A5, 8'(i));
            apply_and_check(5'h07, 16'h1234, 16'h0, 16'hC3A5, 8'(i));
        end

        // Mixed pseudo-random run over all requirements
        begin
            logic [31:0] lf = 32'h1ACE_B00C;
            for (int n = 0; n < 3000; n++) begin
                logic [15:0] a, b, d;
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                a = lf[15:0];
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                b = lf[31:16] ^ lf[15:0];
                d = lf[23:8];
                apply_and_check(lf[4:0], a, b, d, lf[12:5]);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule